// File: doc/BRIEF.md
# Post-Update Load Execution Unit

This unit executes 64-bit load operations that write two registers. The address sent to memory is the base register's value as it was when the operation was issued. Nothing is added to it before the access. The returned byte, halfword, word or doubleword is zero-extended or sign-extended into the target register. The base register is then overwritten with the base plus an offset. In immediate mode the offset is a sign-extended displacement. In indexed mode it is a second register value.

An upstream decoder supplies the decoded fields. The unit takes one operation while idle and issues one read request, which waits for the memory to accept it. It then waits for the read response. Both register writebacks and a one-cycle done pulse appear together one cycle after the response. If the register combination is not allowed, the unit raises an illegal-form pulse instead and makes no memory request and no writeback.

Top module: `ldu_post_update`

## Requirements
- R1: The request address is the base value `ra_val_i` captured at issue, with no offset added. `mem_req_size_o` encodes the access width in bytes as 1, 2, 4 or 8 for `size_i` equal to 0, 1, 2 or 3. The request stays asserted, with a stable address, until `mem_req_ready_i` is high.
- R2: In immediate mode (`indexed_i`=0) with `size_i` 0, 1 or 2, the base writeback value is `ra_val_i` plus the 16-bit `disp_i` sign-extended to 64 bits.
- R3: In immediate mode with `size_i`=3, the offset is `disp_i[13:0]` with two zero bits appended below it, sign-extended from bit 15 of that result. `disp_i[15:14]` have no effect.
- R4: In indexed mode the base writeback value is `ra_val_i + rb_val_i` modulo 2^64, and it wraps with no overflow indication.
- R5: With `signed_i`=0, a byte, halfword or word load writes the low 8, 16 or 32 bits of `mem_rsp_data_i` and clears the bits above them. Response bits above the access width have no effect. A byte load is always zero-extended, whatever `signed_i` is.
- R6: With `signed_i`=1, a halfword or word load fills every bit above bit 15 or bit 31 with that bit.
- R7: A doubleword load writes all 64 response bits unchanged.
- R8: If `ra_idx_i` is 0 or equals `rt_idx_i` at issue, `illegal_o` pulses for one cycle in the cycle after issue. No request and no writeback follow.
- R9: `rt_we_o`, `ra_we_o` and `done_o` are high together for exactly one cycle, in the cycle after the response is accepted. They carry the register numbers captured at issue.
- R10: `busy_o` is high from the cycle the request is raised until the writeback cycle. While it is high, `issue_ready_o` is low and an asserted `issue_valid_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| issue_valid_i | input | 1 | Operation offered |
| issue_ready_o | output | 1 | Unit idle, operation accepted |
| size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| signed_i | input | 1 | Sign-extend the loaded item |
| indexed_i | input | 1 | 1: offset is rb_val_i; 0: displacement |
| rt_idx_i | input | 5 | Target register number |
| ra_idx_i | input | 5 | Base register number |
| ra_val_i | input | 64 | Base register value |
| rb_val_i | input | 64 | Index register value |
| disp_i | input | 16 | Raw displacement field |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_req_addr_o | output | 64 | Read address |
| mem_req_size_o | output | 4 | Access width in bytes |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Right-justified read data |
| rt_we_o | output | 1 | Target write enable |
| rt_idx_o | output | 5 | Target register number |
| rt_data_o | output | 64 | Extended load value |
| ra_we_o | output | 1 | Base write enable |
| ra_idx_o | output | 5 | Base register number |
| ra_data_o | output | 64 | Updated base value |
| done_o | output | 1 | Operation completed |
| illegal_o | output | 1 | Illegal register combination |
| busy_o | output | 1 | Operation in flight |

## Verification
The assertions assume that the memory raises `mem_rsp_valid_i` only after it has accepted a request, and only once per request. The completion check ties `done_o` to a response in the previous cycle, and that link holds only under this assumption. The bench's memory model drives the response only after it has seen the request handshake, and it drives it for exactly one cycle. It keeps `mem_rsp_valid_i` low at all other times, including during the illegal-form scenarios.

// File: rtl/ldu_pkg.sv
package ldu_pkg;
  typedef enum logic [1:0] {SZ_BYTE, SZ_HALF, SZ_WORD, SZ_DWORD} acc_size_e;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_WB} ldu_state_e;
endpackage

// File: rtl/ldu_form_check.sv
module ldu_form_check #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] ra_idx_i,
  input  logic [REG_W-1:0] rt_idx_i,
  output logic             bad_o
);
  always_comb bad_o = (ra_idx_i == '0) || (ra_idx_i == rt_idx_i);
endmodule

// File: rtl/ldu_update.sv
module ldu_update #(
  parameter int XLEN   = 64,
  parameter int DISP_W = 16
) (
  input  logic [XLEN-1:0]   ra_val_i,
  input  logic [XLEN-1:0]   rb_val_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              indexed_i,
  input  logic              dword_i,
  output logic [XLEN-1:0]   sum_o
);
  logic [DISP_W-1:0] disp_eff;
  logic [XLEN-1:0]   offset;

  always_comb begin
    // doubleword immediate: field scaled by 4, top two raw bits dropped
    disp_eff = dword_i ? {disp_i[DISP_W-3:0], 2'b00} : disp_i;
    offset   = indexed_i ? rb_val_i
                         : {{(XLEN-DISP_W){disp_eff[DISP_W-1]}}, disp_eff};
    sum_o    = ra_val_i + offset;
  end
endmodule

// File: rtl/ldu_extend.sv
module ldu_extend
  import ldu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  acc_size_e       size_i,
  input  logic            signed_i,
  input  logic [XLEN-1:0] raw_i,
  output logic [XLEN-1:0] data_o
);
  always_comb begin
    unique case (size_i)
      SZ_BYTE:  data_o = {{(XLEN-8){1'b0}}, raw_i[7:0]};
      SZ_HALF:  data_o = {{(XLEN-16){signed_i & raw_i[15]}}, raw_i[15:0]};
      SZ_WORD:  data_o = {{(XLEN-32){signed_i & raw_i[31]}}, raw_i[31:0]};
      default:  data_o = raw_i;
    endcase
  end
endmodule

// File: rtl/ldu_post_update.sv
module ldu_post_update
  import ldu_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int REG_W  = 5,
  parameter int DISP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_valid_i,
  output logic              issue_ready_o,
  input  logic [1:0]        size_i,
  input  logic              signed_i,
  input  logic              indexed_i,
  input  logic [REG_W-1:0]  rt_idx_i,
  input  logic [REG_W-1:0]  ra_idx_i,
  input  logic [XLEN-1:0]   ra_val_i,
  input  logic [XLEN-1:0]   rb_val_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [XLEN-1:0]   mem_req_addr_o,
  output logic [3:0]        mem_req_size_o,
  input  logic              mem_rsp_valid_i,
  input  logic [XLEN-1:0]   mem_rsp_data_i,
  output logic              rt_we_o,
  output logic [REG_W-1:0]  rt_idx_o,
  output logic [XLEN-1:0]   rt_data_o,
  output logic              ra_we_o,
  output logic [REG_W-1:0]  ra_idx_o,
  output logic [XLEN-1:0]   ra_data_o,
  output logic              done_o,
  output logic              illegal_o,
  output logic              busy_o
);
  ldu_state_e       state_q;
  acc_size_e        size_q;
  logic             signed_q;
  logic [REG_W-1:0] rt_idx_q, ra_idx_q;
  logic [XLEN-1:0]  addr_q, upd_q, data_q;
  logic             illegal_q;

  logic             bad_form;
  logic             issue_fire;
  logic [XLEN-1:0]  upd_sum;
  logic [XLEN-1:0]  ext_data;

  ldu_form_check #(.REG_W(REG_W)) u_form (
    .ra_idx_i (ra_idx_i),
    .rt_idx_i (rt_idx_i),
    .bad_o    (bad_form)
  );

  ldu_update #(.XLEN(XLEN), .DISP_W(DISP_W)) u_update (
    .ra_val_i  (ra_val_i),
    .rb_val_i  (rb_val_i),
    .disp_i    (disp_i),
    .indexed_i (indexed_i),
    .dword_i   (acc_size_e'(size_i) == SZ_DWORD),
    .sum_o     (upd_sum)
  );

  ldu_extend #(.XLEN(XLEN)) u_extend (
    .size_i   (size_q),
    .signed_i (signed_q),
    .raw_i    (mem_rsp_data_i),
    .data_o   (ext_data)
  );

  assign issue_fire = issue_valid_i && (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      size_q    <= SZ_BYTE;
      signed_q  <= 1'b0;
      rt_idx_q  <= '0;
      ra_idx_q  <= '0;
      addr_q    <= '0;
      upd_q     <= '0;
      data_q    <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= issue_fire && bad_form;
      unique case (state_q)
        ST_IDLE: if (issue_fire && !bad_form) begin
          size_q   <= acc_size_e'(size_i);
          signed_q <= signed_i;
          rt_idx_q <= rt_idx_i;
          ra_idx_q <= ra_idx_i;
          addr_q   <= ra_val_i;  // post-update: old base is the address
          upd_q    <= upd_sum;
          state_q  <= ST_REQ;
        end
        ST_REQ:  if (mem_req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid_i) begin
          data_q  <= ext_data;
          state_q <= ST_WB;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    issue_ready_o   = (state_q == ST_IDLE);
    busy_o          = (state_q != ST_IDLE);
    mem_req_valid_o = (state_q == ST_REQ);
    mem_req_addr_o  = addr_q;
    mem_req_size_o  = 4'd1 << size_q;
    done_o          = (state_q == ST_WB);
    rt_we_o         = done_o;
    ra_we_o         = done_o;
    rt_idx_o        = rt_idx_q;
    ra_idx_o        = ra_idx_q;
    rt_data_o       = data_q;
    ra_data_o       = upd_q;
    illegal_o       = illegal_q;
  end
endmodule

// File: rtl/ldu_post_update_chk.sv
module ldu_post_update_chk #(
  parameter int XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            issue_ready_o,
  input logic            mem_req_valid_o,
  input logic            mem_req_ready_i,
  input logic [XLEN-1:0] mem_req_addr_o,
  input logic            mem_rsp_valid_i,
  input logic            rt_we_o,
  input logic            ra_we_o,
  input logic            done_o,
  input logic            illegal_o,
  input logic            busy_o
);
  a_r1_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  a_r8_illegal_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !mem_req_valid_o && !rt_we_o && !ra_we_o);

  a_r8_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({illegal_o, done_o, mem_req_valid_o}));

  a_r9_done_after_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_rsp_valid_i));

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_busy_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> busy_o && !issue_ready_o);
endmodule

bind ldu_post_update ldu_post_update_chk #(.XLEN(XLEN)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .issue_ready_o   (issue_ready_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o),
  .mem_rsp_valid_i (mem_rsp_valid_i),
  .rt_we_o         (rt_we_o),
  .ra_we_o         (ra_we_o),
  .done_o          (done_o),
  .illegal_o       (illegal_o),
  .busy_o          (busy_o)
);

// File: tb/ldu_post_update_test.sv
module ldu_post_update_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        issue_valid_i = 1'b0;
  logic        issue_ready_o;
  logic [1:0]  size_i = '0;
  logic        signed_i = 1'b0;
  logic        indexed_i = 1'b0;
  logic [4:0]  rt_idx_i = '0;
  logic [4:0]  ra_idx_i = '0;
  logic [63:0] ra_val_i = '0;
  logic [63:0] rb_val_i = '0;
  logic [15:0] disp_i = '0;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [63:0] mem_req_addr_o;
  logic [3:0]  mem_req_size_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [63:0] mem_rsp_data_i = '0;
  logic        rt_we_o, ra_we_o, done_o, illegal_o, busy_o;
  logic [4:0]  rt_idx_o, ra_idx_o;
  logic [63:0] rt_data_o, ra_data_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk_i = ~clk_i;

  ldu_post_update uut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Issue one legal load, serve memory, check request and writeback.
  task automatic do_load(input string tag, input logic [1:0] sz, input logic sgn,
                         input logic idx, input logic [4:0] rt, input logic [4:0] ra,
                         input logic [63:0] rav, input logic [63:0] rbv,
                         input logic [15:0] disp, input logic [63:0] rsp,
                         input logic [63:0] exp_rt, input logic [63:0] exp_ra,
                         input int rsp_delay, input logic poke_busy);
    int n;
    @(negedge clk_i);
    issue_valid_i = 1'b1; size_i = sz; signed_i = sgn; indexed_i = idx;
    rt_idx_i = rt; ra_idx_i = ra; ra_val_i = rav; rb_val_i = rbv; disp_i = disp;
    @(negedge clk_i);
    issue_valid_i = 1'b0;
    n = 0;
    while (!mem_req_valid_o && n < 10) begin @(negedge clk_i); n++; end
    chk({"R1 req valid ", tag}, 64'(mem_req_valid_o), 64'd1);
    chk({"R1 addr ", tag}, mem_req_addr_o, rav);
    chk({"R1 size ", tag}, 64'(mem_req_size_o), 64'd1 << sz);
    chk({"R10 busy ", tag}, {62'd0, busy_o, issue_ready_o}, 64'd2);
    // hold one cycle without ready
    @(negedge clk_i);
    chk({"R1 held ", tag}, {mem_req_valid_o, mem_req_addr_o[62:0]}, {1'b1, rav[62:0]});
    mem_req_ready_i = 1'b1;
    @(negedge clk_i);
    mem_req_ready_i = 1'b0;
    chk({"R1 drop ", tag}, 64'(mem_req_valid_o), 64'd0);
    for (int i = 0; i < rsp_delay; i++) begin
      if (poke_busy) begin
        issue_valid_i = 1'b1; rt_idx_i = 5'd30; ra_idx_i = 5'd31;
        ra_val_i = 64'hBAD0; size_i = 2'd3; indexed_i = 1'b1;
      end
      chk({"R10 wait ", tag}, {62'd0, busy_o, issue_ready_o}, 64'd2);
      @(negedge clk_i);
      issue_valid_i = 1'b0;
    end
    mem_rsp_valid_i = 1'b1; mem_rsp_data_i = rsp;
    @(negedge clk_i);
    mem_rsp_valid_i = 1'b0; mem_rsp_data_i = '1;
    chk({"R9 strobes ", tag}, {61'd0, rt_we_o, ra_we_o, done_o}, 64'd7);
    chk({"R9 idx ", tag}, {54'd0, rt_idx_o, ra_idx_o}, {54'd0, rt, ra});
    chk({"R5/R6/R7 data ", tag}, rt_data_o, exp_rt);
    chk({"R2/R3/R4 base ", tag}, ra_data_o, exp_ra);
    @(negedge clk_i);
    chk({"R9 one pulse ", tag}, {61'd0, rt_we_o, ra_we_o, done_o}, 64'd0);
    chk({"R10 idle ", tag}, {62'd0, busy_o, issue_ready_o}, 64'd1);
  endtask

  task automatic do_illegal(input string tag, input logic [4:0] rt, input logic [4:0] ra);
    int seen;
    @(negedge clk_i);
    issue_valid_i = 1'b1; size_i = 2'd2; signed_i = 1'b0; indexed_i = 1'b0;
    rt_idx_i = rt; ra_idx_i = ra; ra_val_i = 64'h4000; disp_i = 16'h8;
    @(negedge clk_i);
    issue_valid_i = 1'b0;
    chk({"R8 flag ", tag}, 64'(illegal_o), 64'd1);
    seen = 0;
    for (int i = 0; i < 5; i++) begin
      if (mem_req_valid_o || rt_we_o || ra_we_o || busy_o) seen++;
      @(negedge clk_i);
      if (i == 0) chk({"R8 pulse ", tag}, 64'(illegal_o), 64'd0);
    end
    chk({"R8 quiet ", tag}, 64'(seen), 64'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R10 reset idle", {60'd0, busy_o, issue_ready_o, mem_req_valid_o, done_o}, 64'd4);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R9 reset strobes", {61'd0, rt_we_o, ra_we_o, illegal_o}, 64'd0);

    // R5: byte, zero-extended even with signed flag, upper response junk ignored; R2
    do_load("byte", 2'd0, 1'b1, 1'b0, 5'd3, 5'd4, 64'h1000, 64'h0, 16'h0008,
            64'hDEADBEEF_CAFE12F0, 64'hF0, 64'h1008, 1, 1'b0);
    // R5 halfword zero-ext, R2 negative displacement
    do_load("half_u", 2'd1, 1'b0, 1'b0, 5'd5, 5'd6, 64'h2000, 64'h0, 16'hFFFC,
            64'h1111_2222_3333_8001, 64'h8001, 64'h1FFC, 2, 1'b0);
    // R6 signed halfword negative, R4 indexed, R10 issue ignored while busy
    do_load("half_s", 2'd1, 1'b1, 1'b1, 5'd7, 5'd8, 64'h3000, 64'h10, 16'h7FFF,
            64'h0000_0000_0000_8001, 64'hFFFF_FFFF_FFFF_8001, 64'h3010, 3, 1'b1);
    // R6 signed halfword positive
    do_load("half_sp", 2'd1, 1'b1, 1'b0, 5'd9, 5'd10, 64'h10, 64'h0, 16'h0002,
            64'hFFFF_FFFF_FFFF_7FFE, 64'h7FFE, 64'h12, 0, 1'b0);
    // R6 signed word
    do_load("word_s", 2'd2, 1'b1, 1'b0, 5'd11, 5'd12, 64'h5000, 64'h0, 16'h0004,
            64'h1234_5678_8000_0000, 64'hFFFF_FFFF_8000_0000, 64'h5004, 1, 1'b0);
    // R5 unsigned word
    do_load("word_u", 2'd2, 1'b0, 1'b1, 5'd13, 5'd14, 64'h6000, 64'hFFFF_FFFF_FFFF_FFF8,
            16'h0, 64'h1234_5678_90AB_CDEF, 64'h90AB_CDEF, 64'h5FF8, 1, 1'b0);
    // R3 doubleword immediate: field 5 -> +20, top raw bits ignored; R7
    do_load("dw_pos", 2'd3, 1'b0, 1'b0, 5'd15, 5'd16, 64'h100, 64'h0, 16'hC005,
            64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001, 64'h114, 1, 1'b0);
    // R3 field all ones -> -4
    do_load("dw_neg", 2'd3, 1'b1, 1'b0, 5'd17, 5'd18, 64'h100, 64'h0, 16'h3FFF,
            64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 64'hFC, 2, 1'b0);
    // R4 wrap modulo 2^64, R7
    do_load("dw_wrap", 2'd3, 1'b0, 1'b1, 5'd19, 5'd20, 64'hFFFF_FFFF_FFFF_FFF0, 64'h20,
            16'h0, 64'hFEDC_BA98_7654_3210, 64'hFEDC_BA98_7654_3210, 64'h10, 1, 1'b0);
    // R8 illegal forms
    do_illegal("ra_zero", 5'd3, 5'd0);
    do_illegal("ra_eq_rt", 5'd7, 5'd7);
    // recovers after illegal
    do_load("after_ill", 2'd0, 1'b0, 1'b0, 5'd1, 5'd2, 64'h77, 64'h0, 16'h0001,
            64'h55, 64'h55, 64'h78, 0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule